// File: doc/BRIEF.md
# In-Order Pipeline Interlock Controller

This block decides, every cycle, whether the instruction sitting in decode of a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, write-back) may move on. The pipeline has no operand forwarding and no branch prediction. Every hazard is therefore resolved by waiting. A consumer stays in decode until its producer has reached write-back. Fetch freezes while a branch travels from decode to execute, where its outcome becomes known.

The block compares the two source register numbers of the decoded instruction with the destinations of the instructions in execute and memory. It drives three controls: a fetch hold, a decode hold, and a bubble request into execute. It also holds the architectural register file. A write-back write lands before the decode read in the same cycle, so a producer in write-back never stalls its consumer. Instruction decode, the ALU and the data memory sit outside the block and feed it stage information.

Top module: `pipe_interlock`

## Requirements
- R1: After reset is released, with no valid instruction in decode, fetch hold, decode hold and bubble are all low, and every register reads as zero.
- R2: A write-back write (write flag high, destination non-zero) is returned on a decode read of the same register in the same cycle, and the value is kept for later reads.
- R3: Decode hold is high when a used, non-zero source of a valid decoded instruction equals the destination of the execute or memory stage while that stage's write flag is set. This applies equally to ALU operands and store data.
- R4: A match with the write-back destination alone never holds decode. A consumer directly after its producer is held exactly two cycles, and a consumer with one unrelated instruction between them is held exactly one cycle.
- R5: A valid branch in decode raises fetch hold in every cycle it stays in decode and in the one cycle after it leaves decode.
- R6: Whenever decode hold is high, fetch hold and the bubble request are also high. The bubble request is never high without decode hold.
- R7: Register 0 reads as zero, ignores writes and never causes a hold.
- R8: A source whose use flag is clear, a destination whose write flag is clear, and an invalid decode slot never cause a decode hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_src_a | input | 5 | First source register number |
| dec_use_a | input | 1 | First source is read |
| dec_src_b | input | 5 | Second source register number |
| dec_use_b | input | 1 | Second source is read |
| dec_branch | input | 1 | Instruction in decode is a conditional branch |
| ex_dst | input | 5 | Destination of the execute stage |
| ex_wr | input | 1 | Execute stage will write its destination |
| mem_dst | input | 5 | Destination of the memory stage |
| mem_wr | input | 1 | Memory stage will write its destination |
| wb_dst | input | 5 | Destination of the write-back stage |
| wb_wr | input | 1 | Write-back stage writes its destination now |
| wb_value | input | 32 | Result being written back |
| fetch_hold | output | 1 | Freeze the program counter and fetch register |
| dec_hold | output | 1 | Keep the decode register contents |
| ex_bubble | output | 1 | Load execute with a bubble that has every write flag clear |
| src_a_value | output | 32 | Register file value of the first source |
| src_b_value | output | 32 | Register file value of the second source |

## Verification
A branch whose operand depends on an instruction still in execute or memory lands in the same cycle as the data interlock, so two reasons for fetch hold overlap. The random phase hands out register numbers from a small pool and raises the branch flag often, so branches are held in decode repeatedly. The reference model then expects fetch hold through the whole stall and for exactly one more cycle after release. A second collision, a write-back write to the register being read in the same cycle, is judged by comparing the read value with the freshly written data.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam int unsigned XLEN_D = 32;
  localparam int unsigned NREG_D = 32;
  localparam int unsigned NSRC   = 2;
endpackage

// File: rtl/pil_regfile.sv
module pil_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned NRD  = 2,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [RW-1:0]           wr_idx,
  input  logic [XLEN-1:0]         wr_data,
  input  logic [NRD-1:0][RW-1:0]  rd_idx,
  output logic [NRD-1:0][XLEN-1:0] rd_data
);
  logic [NREG-1:0][XLEN-1:0] cell_q;

  // entry 0 is tied to zero; others have their own enable
  assign cell_q[0] = '0;
  for (genvar e = 1; e < NREG; e++) begin : g_cell
    logic cell_en;
    assign cell_en = wr_en && (wr_idx == RW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q[e] <= '0;
      else if (cell_en) cell_q[e] <= wr_data;
    end
  end

  // write-first read: same-cycle write is returned
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (wr_en && (wr_idx == rd_idx[p]) && (rd_idx[p] != '0))
        rd_data[p] = wr_data;
      else
        rd_data[p] = cell_q[rd_idx[p]];
    end
  end
endmodule

// File: rtl/pil_src_cmp.sv
module pil_src_cmp #(
  parameter int unsigned RW = 5
) (
  input  logic          use_src,
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  output logic          conflict
);
  logic hit_ex;
  logic hit_mem;
  always_comb begin
    hit_ex   = ex_wr  && (ex_dst  == src);
    hit_mem  = mem_wr && (mem_dst == src);
    conflict = use_src && (src != '0) && (hit_ex || hit_mem);
  end
endmodule

// File: rtl/pil_branch_shadow.sv
module pil_branch_shadow (
  input  logic clk,
  input  logic rst_n,
  input  logic br_in_dec,
  input  logic stall,
  output logic shadow
);
  logic shadow_d;
  logic shadow_q;

  always_comb shadow_d = br_in_dec && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= 1'b0;
    else        shadow_q <= shadow_d;
  end

  assign shadow = shadow_q;
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int unsigned XLEN = pil_pkg::XLEN_D,
  parameter int unsigned NREG = pil_pkg::NREG_D,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic [RW-1:0]   dec_src_a,
  input  logic            dec_use_a,
  input  logic [RW-1:0]   dec_src_b,
  input  logic            dec_use_b,
  input  logic            dec_branch,
  input  logic [RW-1:0]   ex_dst,
  input  logic            ex_wr,
  input  logic [RW-1:0]   mem_dst,
  input  logic            mem_wr,
  input  logic [RW-1:0]   wb_dst,
  input  logic            wb_wr,
  input  logic [XLEN-1:0] wb_value,
  output logic            fetch_hold,
  output logic            dec_hold,
  output logic            ex_bubble,
  output logic [XLEN-1:0] src_a_value,
  output logic [XLEN-1:0] src_b_value
);
  localparam int unsigned NS = pil_pkg::NSRC;

  logic [NS-1:0][RW-1:0]   src_idx;
  logic [NS-1:0]           src_use;
  logic [NS-1:0]           src_conf;
  logic [NS-1:0][XLEN-1:0] src_val;
  logic                    rf_we;
  logic                    br_dec;
  logic                    br_shadow;

  assign src_idx = {dec_src_b, dec_src_a};
  assign src_use = {dec_use_b, dec_use_a};
  assign rf_we   = wb_wr && (wb_dst != '0);

  for (genvar s = 0; s < NS; s++) begin : g_cmp
    pil_src_cmp #(.RW(RW)) u_cmp (
      .use_src (src_use[s]),
      .src     (src_idx[s]),
      .ex_dst  (ex_dst),
      .ex_wr   (ex_wr),
      .mem_dst (mem_dst),
      .mem_wr  (mem_wr),
      .conflict(src_conf[s])
    );
  end

  always_comb begin
    dec_hold  = dec_valid && (|src_conf);
    ex_bubble = dec_hold;
    br_dec    = dec_valid && dec_branch;
  end

  pil_branch_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_in_dec(br_dec),
    .stall    (dec_hold),
    .shadow   (br_shadow)
  );

  always_comb fetch_hold = dec_hold || br_dec || br_shadow;

  pil_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NS)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (rf_we),
    .wr_idx (wb_dst),
    .wr_data(wb_value),
    .rd_idx (src_idx),
    .rd_data(src_val)
  );

  assign src_a_value = src_val[0];
  assign src_b_value = src_val[1];
endmodule

// File: rtl/pil_checks.sv
module pil_checks #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_valid,
  input logic [RW-1:0]   dec_src_a,
  input logic            dec_use_a,
  input logic [RW-1:0]   dec_src_b,
  input logic            dec_use_b,
  input logic            dec_branch,
  input logic [RW-1:0]   ex_dst,
  input logic            ex_wr,
  input logic [RW-1:0]   mem_dst,
  input logic            mem_wr,
  input logic [RW-1:0]   wb_dst,
  input logic            wb_wr,
  input logic [XLEN-1:0] wb_value,
  input logic            fetch_hold,
  input logic            dec_hold,
  input logic            ex_bubble,
  input logic [XLEN-1:0] src_a_value,
  input logic [XLEN-1:0] src_b_value
);
  a_r3_ex_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_use_a && dec_src_a != '0 && ex_wr && ex_dst == dec_src_a) |-> dec_hold);

  a_r3_mem_match_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_use_b && dec_src_b != '0 && mem_wr && mem_dst == dec_src_b) |-> dec_hold);

  a_r5_branch_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_branch && !dec_hold) |=> fetch_hold);

  a_r6_hold_implies_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hold |-> (fetch_hold && ex_bubble));

  a_r6_no_lone_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> dec_hold);

  a_r7_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_src_a == '0) |-> (src_a_value == '0));

  a_r8_invalid_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_hold);

  a_r2_wb_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_wr && wb_dst != '0 && dec_src_b == wb_dst) |-> (src_b_value == wb_value));
endmodule

bind pipe_interlock pil_checks #(.XLEN(XLEN), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
  .dec_src_a(dec_src_a), .dec_use_a(dec_use_a),
  .dec_src_b(dec_src_b), .dec_use_b(dec_use_b), .dec_branch(dec_branch),
  .ex_dst(ex_dst), .ex_wr(ex_wr), .mem_dst(mem_dst), .mem_wr(mem_wr),
  .wb_dst(wb_dst), .wb_wr(wb_wr), .wb_value(wb_value),
  .fetch_hold(fetch_hold), .dec_hold(dec_hold), .ex_bubble(ex_bubble),
  .src_a_value(src_a_value), .src_b_value(src_b_value)
);

// File: tb/sim_pipe_interlock.sv
module sim_pipe_interlock;
  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid, dec_use_a, dec_use_b, dec_branch;
  logic [4:0] dec_src_a, dec_src_b, ex_dst, mem_dst, wb_dst;
  logic ex_wr, mem_wr, wb_wr;
  logic [31:0] wb_value;
  logic fetch_hold, dec_hold, ex_bubble;
  logic [31:0] src_a_value, src_b_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [31:0] ref_rf [32];
  bit ref_shadow;
  bit last_hold;

  always #5 clk = ~clk;

  pipe_interlock u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit ref_conf(bit u, logic [4:0] s);
    return u && s != 0 && ((ex_wr && ex_dst == s) || (mem_wr && mem_dst == s));
  endfunction

  function automatic logic [31:0] ref_read(logic [4:0] s);
    if (s == 0) return 32'h0;
    if (wb_wr && wb_dst == s) return wb_value;
    return ref_rf[s];
  endfunction

  // one cycle: compare at negedge, advance model at posedge
  task automatic step();
    bit h, fh;
    @(negedge clk);
    h  = dec_valid && (ref_conf(dec_use_a, dec_src_a) || ref_conf(dec_use_b, dec_src_b));
    fh = h || (dec_valid && dec_branch) || ref_shadow;
    chk("R3/R4/R7/R8 dec_hold", {31'b0, dec_hold}, {31'b0, h});
    chk("R5/R6 fetch_hold", {31'b0, fetch_hold}, {31'b0, fh});
    chk("R6 ex_bubble", {31'b0, ex_bubble}, {31'b0, h});
    chk("R2/R7 src_a_value", src_a_value, ref_read(dec_src_a));
    chk("R2/R7 src_b_value", src_b_value, ref_read(dec_src_b));
    last_hold = dec_hold;
    @(posedge clk);
    if (wb_wr && wb_dst != 0) ref_rf[wb_dst] = wb_value;
    ref_shadow = dec_valid && dec_branch && !h;
    #1;
  endtask

  task automatic idle();
    dec_valid = 0; dec_use_a = 0; dec_use_b = 0; dec_branch = 0;
    dec_src_a = 0; dec_src_b = 0;
    ex_dst = 0; ex_wr = 0; mem_dst = 0; mem_wr = 0;
    wb_dst = 0; wb_wr = 0; wb_value = 0;
  endtask

  // producer writes r5, 'gap' unrelated instrs, consumer reads r5
  task automatic pipe_pair(int gap, int exp_holds);
    int n = gap + 2;
    int dst [8];
    int src [8];
    int ip = 0;
    int e_d = 0, m_d = 0, w_d = 0;
    bit e_w = 0, m_w = 0, w_w = 0;
    int holds = 0;
    for (int k = 0; k < n; k++) begin dst[k] = 10 + k; src[k] = 0; end
    dst[0] = 5; src[n-1] = 5;
    while (ip < n || e_w || m_w || w_w) begin
      dec_valid = (ip < n); dec_branch = 0; dec_use_b = 0; dec_src_b = 0;
      dec_use_a = (ip < n) && src[ip] != 0;
      dec_src_a = (ip < n) ? 5'(src[ip]) : 5'd0;
      ex_dst = 5'(e_d); ex_wr = e_w; mem_dst = 5'(m_d); mem_wr = m_w;
      wb_dst = 5'(w_d); wb_wr = w_w; wb_value = 32'h5A00 + 32'(gap);
      step();
      if (ip == n - 1 && last_hold) holds++;
      w_d = m_d; w_w = m_w; m_d = e_d; m_w = e_w;
      if (last_hold || ip >= n) begin e_d = 0; e_w = 0; end
      else begin e_d = dst[ip]; e_w = 1; ip++; end
    end
    idle();
    chk($sformatf("R4 holds for gap %0d", gap), 32'(holds), 32'(exp_holds));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) ref_rf[i] = 0;
    ref_shadow = 0;
    last_hold = 0;
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    @(negedge clk);
    chk("R1 fetch_hold", {31'b0, fetch_hold}, 32'd0);
    chk("R1 dec_hold", {31'b0, dec_hold}, 32'd0);
    chk("R1 ex_bubble", {31'b0, ex_bubble}, 32'd0);
    for (int r = 0; r < 32; r += 9) begin
      dec_src_a = 5'(r); #1;
      chk("R1 register cleared", src_a_value, 32'd0);
    end
    dec_src_a = 0;
    @(posedge clk); #1;

    // R4 spacing
    pipe_pair(0, 2);
    pipe_pair(1, 1);
    pipe_pair(2, 0);

    // R7: writes to register 0 are dropped
    wb_wr = 1; wb_dst = 0; wb_value = 32'hDEAD; step();
    idle(); step();
    // R8: unused source and clear write flag
    dec_valid = 1; dec_src_a = 3; dec_use_a = 0; ex_dst = 3; ex_wr = 1;
    dec_src_b = 4; dec_use_b = 1; mem_dst = 4; mem_wr = 0; step();
    // R5: branch with operand hazard, then released
    dec_branch = 1; dec_use_b = 1; mem_wr = 1; step();
    mem_wr = 0; step();
    idle(); step(); step();

    // random phase, small register pool
    for (int c = 0; c < 3000; c++) begin
      dec_valid  = ($urandom % 4) != 0;
      dec_src_a  = 5'($urandom % 6);
      dec_src_b  = 5'($urandom % 6);
      dec_use_a  = $urandom % 2;
      dec_use_b  = $urandom % 2;
      dec_branch = ($urandom % 3) == 0;
      ex_dst = 5'($urandom % 6);  ex_wr  = $urandom % 2;
      mem_dst = 5'($urandom % 6); mem_wr = $urandom % 2;
      wb_dst = 5'($urandom % 6);  wb_wr  = $urandom % 2;
      wb_value = $urandom;
      step();
    end
    idle(); step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule